// File: doc/BRIEF.md
# Timestamped Cluster Sample Unpacker

This block expands compressed capture memory into a plain stream of 16-bit samples, one bit per probe. The memory is read out as a stream of 16-bit words grouped into chunks of 64 clusters. Each cluster is eight words: a timestamp word first, then seven event words. Consecutive events are one event period apart. An event carries one, two or four time-consecutive samples, depending on how many probes the capture used (16, 8 or 4). The bits of those samples are interleaved inside the event word.

When a cluster's timestamp shows that time passed with no stored events, the unpacker first repeats the last sample it emitted to fill the gap. It then de-interleaves the seven events into samples. A nonzero limit timestamp cuts a partial final chunk short. The block can also flag the sample that starts a chosen trigger cluster.

Words enter on a valid/ready input and samples leave on a valid/ready output. The input is accepted only while no sample is waiting, and an output sample holds still until it is taken. `start` is a one-cycle pulse that begins a capture and latches the probe mode. The limit and trigger pins are plain control inputs and are held steady while a chunk streams.

Top module: `cluster_unpacker`

## Requirements
- R1: After reset, and in the cycle after a `start` pulse, `out_valid` is low and `in_ready` is high, waiting for a timestamp word.
- R2: In mode 0 (16 probes), each event word gives exactly one output sample, equal to the event word.
- R3: In mode 1 (8 probes), each event gives two samples, k = 0 then 1. Bit l of sample k is event bit 2*l+k for l < 8, and output bits 15:8 are zero.
- R4: In mode 2 (4 probes), each event gives four samples, k = 0 to 3. Bit l of sample k is event bit 4*l+k for l < 4, and output bits 15:4 are zero.
- R5: The first cluster after `start` emits no padding, whatever timestamps came before.
- R6: For every later cluster, let d be the timestamp minus the previous cluster's timestamp. When d > 7, exactly (d-7) times the samples-per-event copies of the last emitted sample are output before the cluster's own samples. When d <= 7, no copies are output.
- R7: Timestamp differences are taken modulo 2^16, so a timestamp that wraps past 0xFFFF pads by its true distance.
- R8: With `limit_ts` nonzero, a cluster whose timestamp is greater than `limit_ts` and all later words of that chunk are consumed with no output. A timestamp equal to the limit decodes normally. The next chunk decodes normally, and its padding is measured from the timestamp that hit the limit. With `limit_ts` zero, no limit applies.
- R9: With `trig_en` high, `out_trig` is high only on the first sample of event 0 of cluster c of each chunk. In mode 0, c = max(trig_pos-6, 0)/7; in other modes, c = trig_pos/7. `trig_pos` is an event index below 448.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. No sample is dropped or duplicated.
- R11: `in_ready` and `out_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture start pulse; latches `mode`, arms first-cluster handling |
| mode | input | 2 | Probe mode: 0 = 16 probes, 1 = 8 probes, 2 = 4 probes |
| limit_ts | input | 16 | Limit timestamp; 0 disables |
| trig_en | input | 1 | Enables trigger marking |
| trig_pos | input | 9 | Trigger event index within the chunk |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Input word (timestamp or event) |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Output sample, probe l at bit l |
| out_ready | input | 1 | Downstream accepts the sample |
| out_trig | output | 1 | Marks the first sample of the trigger cluster |

## Verification
The bench builds the block with its default parameters: 16-bit words, 64 clusters per chunk and 7 events per cluster. With these values a full 512-word chunk streams in, and several consequences come within reach:

- a limit that falls mid-chunk, followed by a second chunk whose padding is measured from the timestamp that hit the limit;
- a gap of more than a hundred event periods, which produces long padding runs under random back-pressure;
- a timestamp sequence that wraps past 0xFFFF;
- trigger clusters both in the middle of the chunk and clamped to cluster 0.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  typedef enum logic [1:0] {
    PM_WIDE    = 2'd0,
    PM_HALF    = 2'd1,
    PM_QUARTER = 2'd2
  } pmode_e;

  typedef enum logic [2:0] {
    ST_TS,
    ST_PAD,
    ST_EVT,
    ST_SPLIT,
    ST_SKIP
  } ust_e;

  // log2 of samples carried by one event
  function automatic logic [1:0] spe_shift(input pmode_e m);
    case (m)
      PM_HALF:    return 2'd1;
      PM_QUARTER: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  // index of the last sample within an event
  function automatic logic [1:0] spe_last(input pmode_e m);
    case (m)
      PM_HALF:    return 2'd1;
      PM_QUARTER: return 2'd3;
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/unpk_deint.sv
module unpk_deint
  import unpk_pkg::*;
#(
  parameter int W = 16
) (
  input  pmode_e         mode,
  input  logic [W-1:0]   evt,
  input  logic [1:0]     sub,
  output logic [W-1:0]   smp
);

  logic [W-1:0] half_v;
  logic [W-1:0] quar_v;

  for (genvar l = 0; l < W; l++) begin : g_probe
    if (l < W / 2) begin : g_half
      logic [1:0] pair;
      assign pair      = evt[2*l +: 2];
      assign half_v[l] = pair[sub[0]];
    end else begin : g_half_zero
      assign half_v[l] = 1'b0;
    end

    if (l < W / 4) begin : g_quar
      logic [3:0] quad;
      assign quad      = evt[4*l +: 4];
      assign quar_v[l] = quad[sub];
    end else begin : g_quar_zero
      assign quar_v[l] = 1'b0;
    end
  end

  always_comb begin
    case (mode)
      PM_HALF:    smp = half_v;
      PM_QUARTER: smp = quar_v;
      default:    smp = evt;
    endcase
  end

endmodule

// File: rtl/unpk_padcalc.sv
module unpk_padcalc
  import unpk_pkg::*;
#(
  parameter int W      = 16,
  parameter int EVENTS = 7,
  localparam int PAD_W = W + 2
) (
  input  logic             first,
  input  logic [W-1:0]     ts,
  input  logic [W-1:0]     prev_ts,
  input  pmode_e           mode,
  output logic [PAD_W-1:0] pad
);

  logic [W-1:0] diff;
  logic [W-1:0] gap;

  // modular difference; the first cluster of a capture counts as one step
  assign diff = first ? W'(1) : ts - prev_ts;
  assign gap  = (diff > W'(EVENTS)) ? diff - W'(EVENTS) : '0;
  assign pad  = {2'b00, gap} << spe_shift(mode);

endmodule

// File: rtl/unpk_trigcalc.sv
module unpk_trigcalc
  import unpk_pkg::*;
#(
  parameter int CLUSTERS = 64,
  parameter int EVENTS   = 7,
  localparam int POS_W   = $clog2(CLUSTERS * EVENTS),
  localparam int CL_W    = $clog2(CLUSTERS)
) (
  input  pmode_e            mode,
  input  logic [POS_W-1:0]  pos,
  output logic [CL_W-1:0]   cl
);

  localparam int LEAD = EVENTS - 1;

  logic [POS_W-1:0] adj;

  always_comb begin
    if (mode == PM_WIDE) begin
      adj = (pos >= POS_W'(LEAD)) ? pos - POS_W'(LEAD) : '0;
    end else begin
      adj = pos;
    end
  end

  assign cl = CL_W'(adj / POS_W'(EVENTS));

endmodule

// File: rtl/cluster_unpacker.sv
module cluster_unpacker
  import unpk_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CLUSTERS = 64,
  parameter int EVENTS   = 7,
  localparam int POS_W   = $clog2(CLUSTERS * EVENTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] limit_ts,
  input  logic              trig_en,
  input  logic [POS_W-1:0]  trig_pos,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              out_trig
);

  localparam int WORDS = CLUSTERS * (EVENTS + 1);
  localparam int WI_W  = $clog2(WORDS);
  localparam int CL_W  = $clog2(CLUSTERS);
  localparam int EV_W  = $clog2(EVENTS);
  localparam int PAD_W = WORD_W + 2;

  ust_e              state;
  pmode_e            mode_q;
  logic              first_q;
  logic [WORD_W-1:0] prev_ts;
  logic [WORD_W-1:0] last_smp;
  logic [WORD_W-1:0] evt_q;
  logic [1:0]        sub_q;
  logic [EV_W-1:0]   ev_idx;
  logic [PAD_W-1:0]  pad_q;
  logic [CL_W-1:0]   clus_q;
  logic [WI_W-1:0]   widx;

  logic              in_fire;
  logic              out_fire;
  logic              chunk_end;
  logic              limit_hit;
  logic              sub_done;
  logic [PAD_W-1:0]  pad_new;
  logic [CL_W-1:0]   trig_cl;
  logic [WORD_W-1:0] split_smp;

  unpk_deint #(.W(WORD_W)) u_deint (
    .mode (mode_q),
    .evt  (evt_q),
    .sub  (sub_q),
    .smp  (split_smp)
  );

  unpk_padcalc #(.W(WORD_W), .EVENTS(EVENTS)) u_pad (
    .first   (first_q),
    .ts      (in_data),
    .prev_ts (prev_ts),
    .mode    (mode_q),
    .pad     (pad_new)
  );

  unpk_trigcalc #(.CLUSTERS(CLUSTERS), .EVENTS(EVENTS)) u_trig (
    .mode (mode_q),
    .pos  (trig_pos),
    .cl   (trig_cl)
  );

  assign in_ready  = (state == ST_TS) || (state == ST_EVT) || (state == ST_SKIP);
  assign out_valid = (state == ST_PAD) || (state == ST_SPLIT);
  assign out_data  = (state == ST_PAD) ? last_smp : split_smp;
  assign out_trig  = trig_en && (state == ST_SPLIT) && (clus_q == trig_cl)
                     && (ev_idx == '0) && (sub_q == 2'd0);

  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign chunk_end = (widx == WI_W'(WORDS - 1));
  assign limit_hit = (limit_ts != '0) && (in_data > limit_ts);
  assign sub_done  = (sub_q == spe_last(mode_q));

  // word position inside the chunk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx <= '0;
    end else if (start) begin
      widx <= '0;
    end else if (in_fire) begin
      widx <= chunk_end ? '0 : widx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_TS;
      mode_q   <= PM_WIDE;
      first_q  <= 1'b1;
      prev_ts  <= '0;
      last_smp <= '0;
      evt_q    <= '0;
      sub_q    <= 2'd0;
      ev_idx   <= '0;
      pad_q    <= '0;
      clus_q   <= '0;
    end else if (start) begin
      state    <= ST_TS;
      mode_q   <= pmode_e'(mode);
      first_q  <= 1'b1;
      last_smp <= '0;
      sub_q    <= 2'd0;
      ev_idx   <= '0;
      pad_q    <= '0;
    end else begin
      case (state)
        ST_TS: begin
          if (in_fire) begin
            prev_ts <= in_data;
            first_q <= 1'b0;
            ev_idx  <= '0;
            clus_q  <= CL_W'(widx / WI_W'(EVENTS + 1));
            if (limit_hit) begin
              state <= ST_SKIP;
            end else if (pad_new != '0) begin
              pad_q <= pad_new;
              state <= ST_PAD;
            end else begin
              state <= ST_EVT;
            end
          end
        end
        ST_PAD: begin
          if (out_fire) begin
            pad_q <= pad_q - 1'b1;
            if (pad_q == PAD_W'(1)) begin
              state <= ST_EVT;
            end
          end
        end
        ST_EVT: begin
          if (in_fire) begin
            evt_q <= in_data;
            sub_q <= 2'd0;
            state <= ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          if (out_fire) begin
            last_smp <= split_smp;
            if (sub_done) begin
              sub_q <= 2'd0;
              if (ev_idx == EV_W'(EVENTS - 1)) begin
                state <= ST_TS;
              end else begin
                ev_idx <= ev_idx + 1'b1;
                state  <= ST_EVT;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
        end
        ST_SKIP: begin
          if (in_fire && chunk_end) begin
            state <= ST_TS;
          end
        end
        default: state <= ST_TS;
      endcase
    end
  end

endmodule

// File: rtl/unpk_chk.sv
module unpk_chk
  import unpk_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input pmode_e       mode_q,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_ready,
  input logic         out_trig
);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!out_valid && in_ready)); // R1

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == PM_HALF) |-> (out_data[W-1:W/2] == '0)); // R3

  AST_QUARTER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == PM_QUARTER) |-> (out_data[W-1:W/4] == '0)); // R4

  AST_TRIG_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_trig |-> out_valid); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data))); // R10

  AST_ONE_SIDE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready)); // R11

endmodule

bind cluster_unpacker unpk_chk #(.W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mode_q    (mode_q),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .out_trig  (out_trig)
);

// File: tb/cluster_unpacker_tb.sv
module cluster_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] limit_ts = '0;
  logic        trig_en = 1'b0;
  logic [8:0]  trig_pos = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ready = 1'b1;
  logic        out_trig;

  always #10 clk = ~clk;

  cluster_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .limit_ts(limit_ts), .trig_en(trig_en), .trig_pos(trig_pos),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .out_trig(out_trig)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] got_d[$];
  bit          got_t[$];
  logic [15:0] exp_d[$];

  bit          bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int          r10_bad = 0;
  int          r11_bad = 0;
  bit          prev_stall = 1'b0;
  logic [15:0] prev_data = '0;

  // model state
  logic [15:0] m_prev = '0;
  logic [15:0] m_last = '0;
  bit          m_fresh = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // downstream ready, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_en ? (lfsr[1:0] != 2'b00) : 1'b1;
    end
  end

  // observer at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(out_valid && out_data == prev_data)) r10_bad++;
      if (out_valid && in_ready) r11_bad++;
      if (out_valid && out_ready) begin
        got_d.push_back(out_data);
        got_t.push_back(out_trig);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  function automatic logic [15:0] deint_m(input logic [15:0] evt, input int sh, input int k);
    logic [15:0] r = '0;
    int spe = 1 << sh;
    for (int l = 0; l < (16 >> sh); l++) r[l] = evt[l * spe + k];
    return r;
  endfunction

  task automatic do_start(input int sh);
    mode  = 2'(sh);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_fresh = 1'b1;
    m_last  = '0;
  endtask

  // one chunk: build, model, stream, compare
  task automatic run_chunk(input string tag, input int sh, input logic [15:0] base,
                           input int gap_big, input int lim_cl, input int tpos);
    logic [15:0] w[512];
    logic [15:0] ts = base;
    logic [15:0] lim = '0;
    logic [15:0] diff;
    logic [15:0] s;
    bit stop = 1'b0;
    int tidx = -1;
    int tcl = -1;
    int mism = 0;
    int fa = 0;
    int fe = 0;
    int ones = 0;
    int gidx = -1;
    int cap = 0;
    int idle = 0;
    bit took;
    exp_d.delete(); got_d.delete(); got_t.delete();
    if (tpos >= 0) begin
      if (sh == 0) tcl = ((tpos >= 6) ? tpos - 6 : 0) / 7;
      else         tcl = tpos / 7;
    end
    for (int c = 0; c < 64; c++) begin
      if (c > 0) ts = ts + 16'((c % 5 == 3) ? 8 + (c % 3) : 7) + 16'((c == 32) ? gap_big : 0);
      w[c*8] = ts;
      if (c == lim_cl) lim = ts;
      for (int e = 0; e < 7; e++) w[c*8+1+e] = 16'((c * 40503) ^ (e * 965) ^ 23130 ^ (c << e));
    end
    for (int c = 0; c < 64; c++) begin
      ts = w[c*8];
      if (!stop) begin
        if (lim != 0 && ts > lim) begin
          stop = 1'b1;
          m_prev = ts;
          m_fresh = 1'b0;
        end else begin
          diff = m_fresh ? 16'd1 : ts - m_prev;
          m_fresh = 1'b0;
          m_prev = ts;
          if (diff > 7) for (int p = 0; p < ((int'(diff) - 7) << sh); p++) exp_d.push_back(m_last);
          for (int e = 0; e < 7; e++) begin
            for (int k = 0; k < (1 << sh); k++) begin
              s = deint_m(w[c*8+1+e], sh, k);
              if (c == tcl && e == 0 && k == 0) tidx = exp_d.size();
              exp_d.push_back(s);
              m_last = s;
            end
          end
        end
      end
    end
    limit_ts = lim;
    trig_en  = (tpos >= 0);
    trig_pos = 9'((tpos >= 0) ? tpos : 0);
    in_valid = 1'b1;
    for (int i = 0; i < 512; i++) begin
      in_data = w[i];
      do begin
        took = in_ready;
        @(negedge clk);
      end while (!took);
    end
    in_valid = 1'b0;
    while (idle < 6 && cap < 20000) begin
      @(negedge clk);
      cap++;
      if (out_valid) idle = 0; else idle++;
    end
    check(got_d.size() == exp_d.size(), tag, "sample count", got_d.size(), exp_d.size());
    for (int i = 0; i < got_d.size() && i < exp_d.size(); i++) begin
      if (got_d[i] !== exp_d[i]) begin
        if (mism == 0) begin fa = got_d[i]; fe = exp_d[i]; end
        mism++;
      end
    end
    check(mism == 0, tag, "first mismatching sample", fa, fe);
    for (int i = 0; i < got_t.size(); i++) begin
      if (got_t[i]) begin
        ones++;
        if (gidx < 0) gidx = i;
      end
    end
    check(gidx == tidx && ones == ((tidx >= 0) ? 1 : 0), "R9", "trigger sample index", gidx, tidx);
    trig_en  = 1'b0;
    limit_ts = '0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    do_start(0);
    check(!out_valid && in_ready, "R1", "idle after start", out_valid, 0);
  endtask

  task automatic t_wide;
    bp_en = 1'b1;
    do_start(0);
    run_chunk("R2 R6 R10", 0, 16'd100, 0, -1, -1);
    run_chunk("R6", 0, m_prev + 16'd200, 40, -1, -1);
    do_start(0);
    run_chunk("R5", 0, m_prev + 16'd5000, 0, -1, -1);
  endtask

  task automatic t_half;
    do_start(1);
    run_chunk("R3", 1, 16'd3000, 20, -1, -1);
  endtask

  task automatic t_quarter;
    do_start(2);
    run_chunk("R4", 2, 16'd700, 50, -1, -1);
  endtask

  task automatic t_wrap;
    do_start(0);
    run_chunk("R7", 0, 16'hFE80, 100, -1, -1);
    run_chunk("R7", 0, m_prev + 16'd30, 0, -1, -1);
  endtask

  task automatic t_limit;
    do_start(0);
    run_chunk("R8", 0, 16'd1000, 0, 20, -1);
    run_chunk("R8", 0, m_prev + 16'd9, 0, -1, -1);
  endtask

  task automatic t_trig;
    do_start(0);
    run_chunk("R9", 0, 16'd50, 0, -1, 40);
    run_chunk("R9", 0, m_prev + 16'd7, 0, -1, 3);
    do_start(1);
    run_chunk("R9", 1, 16'd90, 0, -1, 40);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_wide();
    t_half();
    t_quarter();
    t_wrap();
    t_limit();
    t_trig();
    check(r10_bad == 0, "R10", "stalled sample changed", r10_bad, 0);
    check(r11_bad == 0, "R11", "input and output open together", r11_bad, 0);
    finish_run();
  end

endmodule